// File: doc/BRIEF.md
# Line Parity Error to Remote Error Indication Inserter

This block checks the line parity of each received frame and reports the outcome to the far end. For every frame, an upstream parity stage presents two bytes: the parity it computed over the frame, and the parity byte that arrived. A one-cycle check strobe marks them valid. The block compares the two bytes and keeps the result in a small register. It then writes that result into the low nibble of one outbound overhead byte, which the transmit path marks with a position strobe.

A run-time mode select chooses how the result is reported:
- **Count mode** reports how many parity bits differed, from 0 to 8.
- **Frame mode** reports a single errored-frame flag, 0 or 1.

When automatic insertion is disabled, a software-supplied nibble is written into that field instead of the held result. Every outbound byte, marked or not, leaves the block exactly one clock after it enters. The position strobe is delayed by the same clock, so it stays aligned with its byte.

Top module: `rei_gen`

## Requirements
- R1: On a marked byte (`oh_pos_i`=1), the output byte one clock later has `oh_o[7:4]` equal to `oh_i[7:4]`.
- R2: With `mode_frame_i`=0 at a check strobe, the held value becomes the number of differing bits between `par_exp_i` and `par_rcv_i`, from 0 up to 8. The held value is the one inserted when automatic insertion is on.
- R3: With `mode_frame_i`=1 at a check strobe, the held value becomes 1 if the two parity bytes differ in at least one bit, and 0 if they are equal.
- R4: The held value changes only on a clock edge where `chk_vld_i`=1. Between strobes it keeps the result of the most recent check.
- R5: While `rst_n`=0, both `oh_o` and `oh_pos_o` are 0. From reset until the first check strobe, the held value is 0.
- R6: On a marked byte, `oh_o[3:0]` one clock later depends on `auto_en_i`. When `auto_en_i`=1 it equals the held value. When `auto_en_i`=0 it equals `sw_nib_i`. Bits [3:0] carry the overhead byte's bits 5 to 8, where bit 1 is the most significant bit.
- R7: An unmarked byte appears unchanged on `oh_o` one clock later, and `oh_pos_o` is `oh_pos_i` delayed by one clock.
- R8: A change of `mode_frame_i` does not alter the value already held. The new encoding applies from the next check strobe.
- R9: When a marked byte and a check strobe arrive in the same cycle, the marked byte carries the value held before that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_vld_i | input | 1 | One-cycle strobe marking the parity bytes valid for a frame |
| par_exp_i | input | 8 | Locally computed line parity byte |
| par_rcv_i | input | 8 | Received line parity byte |
| mode_frame_i | input | 1 | 0 = bit-count report, 1 = errored-frame flag |
| auto_en_i | input | 1 | 1 = insert the held result, 0 = insert `sw_nib_i` |
| sw_nib_i | input | 4 | Software override nibble |
| oh_i | input | 8 | Outbound overhead byte stream |
| oh_pos_i | input | 1 | Marks the byte that carries the error field |
| oh_o | output | 8 | Outbound byte stream, one clock later |
| oh_pos_o | output | 1 | `oh_pos_i` delayed by one clock |

## Verification
The assertions assume that every input is a known value on each clock edge after reset. They also assume that a check strobe lasts exactly one cycle per frame, and that the mode select and override nibble are sampled only on the edges where they matter.

The bench drives every input on the falling clock edge, so each input is stable at the next rising edge. It raises the check strobe for a single cycle at a time. It changes the mode and the automatic-insert enable only between strobes and bytes, except in the one case that deliberately puts a strobe and a marked byte in the same cycle.

// File: rtl/rei_pkg.sv
package rei_pkg;
    localparam int unsigned OH_W  = 8;
    localparam int unsigned NIB_W = 4;
    localparam int unsigned CNT_W = $clog2(OH_W + 1);
endpackage

// File: rtl/rei_bip_cmp.sv
module rei_bip_cmp #(
    parameter int unsigned OH_W  = rei_pkg::OH_W,
    parameter int unsigned CNT_W = rei_pkg::CNT_W
) (
    input  logic [OH_W-1:0]  exp_i,
    input  logic [OH_W-1:0]  rcv_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [OH_W-1:0] diff;

    assign diff = exp_i ^ rcv_i;

    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < OH_W; i++) begin
            cnt_o = cnt_o + CNT_W'(diff[i]);
        end
    end
endmodule

// File: rtl/rei_hold.sv
module rei_hold #(
    parameter int unsigned CNT_W = rei_pkg::CNT_W,
    parameter int unsigned NIB_W = rei_pkg::NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             frame_mode_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [NIB_W-1:0] rei_o
);
    typedef struct packed {
        logic [NIB_W-1:0] rei;
    } hold_s;

    hold_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vld_i) begin
            if (frame_mode_i) begin
                st_d.rei = NIB_W'(cnt_i != '0);
            end else begin
                st_d.rei = NIB_W'(cnt_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rei_o = st_q.rei;
endmodule

// File: rtl/rei_insert.sv
module rei_insert #(
    parameter int unsigned OH_W  = rei_pkg::OH_W,
    parameter int unsigned NIB_W = rei_pkg::NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OH_W-1:0]  oh_i,
    input  logic             pos_i,
    input  logic             auto_en_i,
    input  logic [NIB_W-1:0] rei_i,
    input  logic [NIB_W-1:0] sw_nib_i,
    output logic [OH_W-1:0]  oh_o,
    output logic             pos_o
);
    typedef struct packed {
        logic [OH_W-1:0] oh;
        logic            pos;
    } ins_s;

    ins_s st_d, st_q;
    logic [NIB_W-1:0] nib;

    always_comb begin
        nib       = auto_en_i ? rei_i : sw_nib_i;
        st_d.pos  = pos_i;
        st_d.oh   = oh_i;
        if (pos_i) begin
            st_d.oh[NIB_W-1:0] = nib;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oh_o  = st_q.oh;
    assign pos_o = st_q.pos;
endmodule

// File: rtl/rei_gen.sv
module rei_gen #(
    parameter int unsigned OH_W  = rei_pkg::OH_W,
    parameter int unsigned NIB_W = rei_pkg::NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_vld_i,
    input  logic [OH_W-1:0]  par_exp_i,
    input  logic [OH_W-1:0]  par_rcv_i,
    input  logic             mode_frame_i,
    input  logic             auto_en_i,
    input  logic [NIB_W-1:0] sw_nib_i,
    input  logic [OH_W-1:0]  oh_i,
    input  logic             oh_pos_i,
    output logic [OH_W-1:0]  oh_o,
    output logic             oh_pos_o
);
    localparam int unsigned CNT_W = $clog2(OH_W + 1);

    logic [CNT_W-1:0] err_cnt;
    logic [NIB_W-1:0] rei_q;

    rei_bip_cmp #(.OH_W(OH_W), .CNT_W(CNT_W)) u_cmp (
        .exp_i (par_exp_i),
        .rcv_i (par_rcv_i),
        .cnt_o (err_cnt)
    );

    rei_hold #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .vld_i        (chk_vld_i),
        .frame_mode_i (mode_frame_i),
        .cnt_i        (err_cnt),
        .rei_o        (rei_q)
    );

    rei_insert #(.OH_W(OH_W), .NIB_W(NIB_W)) u_ins (
        .clk       (clk),
        .rst_n     (rst_n),
        .oh_i      (oh_i),
        .pos_i     (oh_pos_i),
        .auto_en_i (auto_en_i),
        .rei_i     (rei_q),
        .sw_nib_i  (sw_nib_i),
        .oh_o      (oh_o),
        .pos_o     (oh_pos_o)
    );
endmodule

// File: rtl/rei_gen_chk.sv
module rei_gen_chk #(
    parameter int unsigned OH_W  = 8,
    parameter int unsigned NIB_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chk_vld_i,
    input logic [OH_W-1:0]  par_exp_i,
    input logic [OH_W-1:0]  par_rcv_i,
    input logic             mode_frame_i,
    input logic             auto_en_i,
    input logic [NIB_W-1:0] sw_nib_i,
    input logic [OH_W-1:0]  oh_i,
    input logic             oh_pos_i,
    input logic [OH_W-1:0]  oh_o,
    input logic             oh_pos_o,
    input logic [NIB_W-1:0] rei_q
);
    logic run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
        end
    end

    a_r5_reset_out: assert property (@(posedge clk)
        !rst_n |=> (!rst_n |-> (oh_o == '0 && !oh_pos_o)));

    a_r7_pos_delay: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> oh_pos_o == $past(oh_pos_i));

    a_r7_pass_unmarked: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !oh_pos_o) |-> oh_o == $past(oh_i));

    a_r1_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && oh_pos_o) |-> oh_o[OH_W-1:NIB_W] == $past(oh_i[OH_W-1:NIB_W]));

    a_r2_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld_i && !mode_frame_i) |=>
            32'(rei_q) == $countones($past(par_exp_i ^ par_rcv_i)));

    a_r3_frame_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld_i && mode_frame_i) |=>
            rei_q == NIB_W'($past(par_exp_i) != $past(par_rcv_i)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !$past(chk_vld_i)) |-> $stable(rei_q));

    a_r6_auto_nib: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && oh_pos_o && $past(auto_en_i)) |-> oh_o[NIB_W-1:0] == $past(rei_q));

    a_r6_sw_nib: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && oh_pos_o && !$past(auto_en_i)) |-> oh_o[NIB_W-1:0] == $past(sw_nib_i));
endmodule

bind rei_gen rei_gen_chk #(.OH_W(OH_W), .NIB_W(NIB_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_vld_i    (chk_vld_i),
    .par_exp_i    (par_exp_i),
    .par_rcv_i    (par_rcv_i),
    .mode_frame_i (mode_frame_i),
    .auto_en_i    (auto_en_i),
    .sw_nib_i     (sw_nib_i),
    .oh_i         (oh_i),
    .oh_pos_i     (oh_pos_i),
    .oh_o         (oh_o),
    .oh_pos_o     (oh_pos_o),
    .rei_q        (rei_q)
);

// File: tb/rei_gen_tb.sv
module rei_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // Each vector: {expected parity, received parity, mode}
    localparam logic [16:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 1'b0}, {8'hFF, 8'h00, 1'b0}, {8'hFF, 8'h00, 1'b1},
        {8'hA5, 8'hA5, 1'b1}, {8'h01, 8'h00, 1'b0}, {8'h80, 8'h00, 1'b1},
        {8'hF0, 8'h0F, 1'b0}, {8'h3C, 8'h3D, 1'b0}, {8'h55, 8'hAA, 1'b1},
        {8'h5A, 8'h5A, 1'b0}, {8'hC3, 8'h81, 1'b0}, {8'h7F, 8'h80, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chk_vld_i = 1'b0;
    logic [7:0] par_exp_i = '0;
    logic [7:0] par_rcv_i = '0;
    logic       mode_frame_i = 1'b0;
    logic       auto_en_i = 1'b1;
    logic [3:0] sw_nib_i = '0;
    logic [7:0] oh_i = '0;
    logic       oh_pos_i = 1'b0;
    logic [7:0] oh_o;
    logic       oh_pos_o;

    int n_tot = 0;
    int n_pass = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rei_gen u_dut (
        .clk(clk), .rst_n(rst_n), .chk_vld_i(chk_vld_i),
        .par_exp_i(par_exp_i), .par_rcv_i(par_rcv_i),
        .mode_frame_i(mode_frame_i), .auto_en_i(auto_en_i),
        .sw_nib_i(sw_nib_i), .oh_i(oh_i), .oh_pos_i(oh_pos_i),
        .oh_o(oh_o), .oh_pos_o(oh_pos_o)
    );

    function automatic logic [3:0] ref_rei(input logic [7:0] a, input logic [7:0] b,
                                           input logic m);
        int c = 0;
        for (int i = 0; i < 8; i++) if (a[i] != b[i]) c++;
        if (m) return (c != 0) ? 4'd1 : 4'd0;
        return 4'(c);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_tot++;
        if (ok) n_pass++;
        else $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    endtask

    // strobe one parity pair (one cycle)
    task automatic strobe(input logic [7:0] e, input logic [7:0] r, input logic m);
        @(negedge clk);
        par_exp_i = e; par_rcv_i = r; mode_frame_i = m; chk_vld_i = 1'b1;
        @(negedge clk);
        chk_vld_i = 1'b0;
    endtask

    // send a marked byte and return the output one clock later
    task automatic send(input logic [7:0] b, input logic pos, output logic [7:0] got,
                        output logic gpos);
        oh_i = b; oh_pos_i = pos;
        @(negedge clk);
        oh_pos_i = 1'b0;
        got = oh_o; gpos = oh_pos_o;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tot++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_pass, n_tot);
            $finish;
        end
    end

    initial begin
        logic [7:0] got, b;
        logic gp;
        logic [3:0] expn;

        // R5: reset state
        oh_i = 8'hFF; oh_pos_i = 1'b1;
        repeat (3) @(negedge clk);
        check(oh_o == 8'h00 && !oh_pos_o, "R5 reset outputs", {23'd0, oh_pos_o, oh_o}, 0);
        oh_pos_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R5: held value is 0 before first strobe
        send(8'hB7, 1'b1, got, gp);
        check(got == 8'hB0 && gp, "R5 initial held zero", got, 8'hB0);

        // R2 R3 R1: vector table
        for (int i = 0; i < NVEC; i++) begin
            strobe(VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
            b = 8'(8'h1F * (i + 3));
            expn = ref_rei(VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
            send(b, 1'b1, got, gp);
            check(got == {b[7:4], expn} && gp,
                  VEC[i][0] ? "R3 R1 frame mode vector" : "R2 R1 count mode vector",
                  got, {b[7:4], expn});
        end

        // R2 R3: random pairs in both modes
        for (int i = 0; i < 40; i++) begin
            logic [7:0] e, r;
            logic m;
            e = 8'($urandom); r = 8'($urandom); m = 1'($urandom);
            if (i == 0) r = ~e;
            if (i == 1) r = e;
            strobe(e, r, m);
            b = 8'($urandom);
            expn = ref_rei(e, r, m);
            send(b, 1'b1, got, gp);
            check(got == {b[7:4], expn}, m ? "R3 random" : "R2 random", got, {b[7:4], expn});
        end

        // R4: value held across several bytes without strobe
        strobe(8'h0F, 8'h00, 1'b0);
        repeat (3) @(negedge clk);
        send(8'h90, 1'b1, got, gp);
        check(got == 8'h94, "R4 hold first", got, 8'h94);
        par_exp_i = 8'hFF; par_rcv_i = 8'h00;
        repeat (2) @(negedge clk);
        send(8'h90, 1'b1, got, gp);
        check(got == 8'h94, "R4 hold without strobe", got, 8'h94);

        // R6: software override
        auto_en_i = 1'b0; sw_nib_i = 4'hA;
        send(8'h63, 1'b1, got, gp);
        check(got == 8'h6A, "R6 override nibble", got, 8'h6A);
        auto_en_i = 1'b1;
        send(8'h63, 1'b1, got, gp);
        check(got == 8'h64, "R6 auto again", got, 8'h64);

        // R7: unmarked bytes untouched, strobe delayed
        send(8'hE7, 1'b0, got, gp);
        check(got == 8'hE7 && !gp, "R7 unmarked passthrough", got, 8'hE7);
        oh_i = 8'h5C; oh_pos_i = 1'b1;
        @(posedge clk); #1;
        check(oh_pos_o, "R7 pos aligned after one clock", oh_pos_o, 1);
        @(negedge clk); oh_pos_i = 1'b0;

        // R8: mode change does not re-encode held value
        strobe(8'h07, 8'h00, 1'b0);
        mode_frame_i = 1'b1;
        send(8'h20, 1'b1, got, gp);
        check(got == 8'h23, "R8 no re-encode", got, 8'h23);
        strobe(8'h07, 8'h00, 1'b1);
        send(8'h20, 1'b1, got, gp);
        check(got == 8'h21, "R8 new mode on strobe", got, 8'h21);

        // R9: strobe and marked byte in same cycle
        @(negedge clk);
        par_exp_i = 8'h1F; par_rcv_i = 8'h00; mode_frame_i = 1'b0; chk_vld_i = 1'b1;
        oh_i = 8'h40; oh_pos_i = 1'b1;
        @(negedge clk);
        chk_vld_i = 1'b0; oh_pos_i = 1'b0;
        check(oh_o == 8'h41, "R9 same cycle uses prior value", oh_o, 8'h41);
        send(8'h40, 1'b1, got, gp);
        check(got == 8'h45, "R9 next byte uses new value", got, 8'h45);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_tot);
        $finish;
    end
endmodule